// File: doc/BRIEF.md
# Single-Cycle Load/Store Core with Linking and Memory-Indirect Jumps

This block is a 32-bit processor that completes one instruction per clock cycle. It fetches from a small word-addressed instruction array and reads and writes a small word-addressed data array, both inside the block. Its integer subset has five register-register ALU operations, word load and store, branch-on-equal and an absolute jump. Three further control-flow and addressing forms extend that subset. A call instruction jumps and saves its return address in register 31. A register-indexed load takes its address from the sum of two registers. A memory-indirect jump takes the next program counter from a data word.

Control fans out from two decoders. The opcode decoder drives three 2-bit selects: destination register (rt, rd, or constant 31), write-back source (ALU, memory, or return address) and next-PC source (sequential/branch, jump target, or memory word). The function decoder picks the ALU operation and recognises the register-indexed load. The core has no handshake. Its only outputs are a debug view of the current instruction address and of the register write made in that cycle. A testbench loads the instruction array before it releases reset.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge the program counter becomes 0. The first instruction after reset is fetched from instruction word 0.
- R2: Opcode 0x00 is register-register. Its function codes are add 0x20, subtract 0x22, and 0x24, or 0x25 and signed set-less-than 0x2A. Each writes rs-op-rt into register rd (field bits 15:11).
- R3: Load (0x23) writes the data word at R[rs] plus the sign-extended 16-bit immediate into rt (bits 20:16). Store (0x2B) writes R[rt] to that address and writes no register. The word index is address bits above bit 1, taken modulo the array depth.
- R4: Branch-equal (0x04) with R[rs]==R[rt] moves the PC to PC+4 plus the sign-extended immediate times 4. Otherwise the PC moves to PC+4. Neither case writes a register.
- R5: Jump (0x02) sets the PC to bits 31:28 of PC+4, followed by the 26-bit target field, followed by two zero bits.
- R6: Call (0x03) uses the same target as R5. In the same cycle it writes PC+4 into register 31.
- R7: Function code 0x30 under opcode 0x00 is the register-indexed load. It writes the data word at R[rs]+R[rt] into rd.
- R8: Opcode 0x3E is the memory-indirect jump. The next PC is the data word at R[rs] plus the sign-extended immediate. It writes no register, and the rt field is ignored.
- R9: Register 0 always reads as zero. A write aimed at it is dropped and does not appear on the debug write port.
- R10: An unknown opcode, or an unknown function code under opcode 0x00, writes no register and no memory, and the PC advances by 4.
- R11: `dbg_pc` shows the address of the instruction executing in the current cycle. `dbg_wr_en`, `dbg_wr_idx` and `dbg_wr_val` show the register write that this instruction commits at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Address of the instruction in execution |
| dbg_wr_en | output | 1 | A register write is committed at the next edge |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_val | output | 32 | Value of that write |

## Verification
Directed programs build operands out of return addresses, because a fresh core has no immediate-load instruction. They then exercise every select value. The call is checked for writing register 31 with PC+4; a core that wired the return value to the ALU result, or linked into rt, shows a wrong index or value. The register-indexed load uses the same register for rs and rt and a distinct rd, so a core that kept the load-style destination would overwrite rs. The memory-indirect jump reads from a negative offset, so a core that loaded the PC from the ALU sum lands four bytes short. Other programs cover a backward branch, a not-taken branch on a linked register, a signed compare across zero, a write to register 0 followed by a read of it, and an unknown opcode and function code. A core that treated these as writes or stalled the PC is caught.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_CALL  = 6'h03;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_MJUMP = 6'h3E;

    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_XLD  = 6'h30;

    localparam logic [4:0] LINK_REG = 5'd31;

    typedef enum logic [1:0] {
        DST_RT   = 2'b00,
        DST_RD   = 2'b01,
        DST_LINK = 2'b10
    } dst_sel_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'b00,
        WB_MEM  = 2'b01,
        WB_LINK = 2'b10
    } wb_sel_e;

    typedef enum logic [1:0] {
        NPC_SEQ = 2'b00,
        NPC_JMP = 2'b01,
        NPC_MEM = 2'b10
    } npc_sel_e;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_cls_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        dst_sel_e dst;
        wb_sel_e  wb;
        npc_sel_e npc;
        logic     use_imm;
        logic     reg_we;
        logic     mem_we;
        logic     branch;
        logic     rtype;
        alu_cls_e cls;
    } ctrl_t;

    typedef struct packed {
        logic [31:0] pc;
    } core_st_t;

endpackage

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
    parameter int N_REGS = 32,
    parameter int DW     = 32,
    localparam int AW    = $clog2(N_REGS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] regs_q [N_REGS];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
        rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
    end

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
    import sc_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output logic          zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
        zero = (a == b);
    end

endmodule

// File: rtl/sc_main_dec.sv
`timescale 1ns/1ps
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{dst: DST_RT, wb: WB_ALU, npc: NPC_SEQ, use_imm: 1'b0,
                 reg_we: 1'b0, mem_we: 1'b0, branch: 1'b0, rtype: 1'b0,
                 cls: CLS_ADD};
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.dst    = DST_RD;
                ctrl.reg_we = 1'b1;
                ctrl.rtype  = 1'b1;
                ctrl.cls    = CLS_FUNCT;
            end
            OP_LOAD: begin
                ctrl.wb      = WB_MEM;
                ctrl.use_imm = 1'b1;
                ctrl.reg_we  = 1'b1;
            end
            OP_STORE: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.cls    = CLS_SUB;
            end
            OP_JUMP: begin
                ctrl.npc = NPC_JMP;
            end
            OP_CALL: begin
                ctrl.dst    = DST_LINK;
                ctrl.wb     = WB_LINK;
                ctrl.reg_we = 1'b1;
                ctrl.npc    = NPC_JMP;
            end
            OP_MJUMP: begin
                ctrl.use_imm = 1'b1;
                ctrl.npc     = NPC_MEM;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu_dec.sv
`timescale 1ns/1ps
module sc_alu_dec
    import sc_pkg::*;
(
    input  alu_cls_e   cls,
    input  logic [5:0] funct,
    output alu_op_e    op,
    output logic       xload,
    output logic       known
);

    always_comb begin
        op    = ALU_ADD;
        xload = 1'b0;
        known = 1'b1;
        unique case (cls)
            CLS_SUB: op = ALU_SUB;
            CLS_FUNCT: begin
                unique case (funct)
                    FN_ADD: op = ALU_ADD;
                    FN_SUB: op = ALU_SUB;
                    FN_AND: op = ALU_AND;
                    FN_OR:  op = ALU_OR;
                    FN_SLT: op = ALU_SLT;
                    FN_XLD: xload = 1'b1;
                    default: known = 1'b0;
                endcase
            end
            default: op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] dbg_pc,
    output logic        dbg_wr_en,
    output logic [4:0]  dbg_wr_idx,
    output logic [31:0] dbg_wr_val
);

    localparam int IA_W = (IMEM_WORDS > 1) ? $clog2(IMEM_WORDS) : 1;
    localparam int DA_W = (DMEM_WORDS > 1) ? $clog2(DMEM_WORDS) : 1;

    logic [31:0] imem_q [IMEM_WORDS];
    logic [31:0] dmem_q [DMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem_q[i] = '0;
    end

    core_st_t core_q, core_d;

    logic [31:0] instr;
    logic [5:0]  opcode, funct;
    logic [4:0]  rs, rt, rd;
    logic [15:0] imm16;
    logic [31:0] imm_ext;
    logic [31:0] rs_val, rt_val;
    logic [31:0] alu_b, alu_y;
    logic        alu_zero;
    logic [31:0] mem_rdata;
    logic [DA_W-1:0] dm_idx;
    logic [31:0] pc_plus4, br_tgt, jmp_tgt;
    ctrl_t       dec_ctrl, ctrl;
    alu_op_e     alu_op;
    logic        fn_xload, fn_known;
    logic        rf_we;
    logic [4:0]  wr_idx;
    logic [31:0] wr_val;
    logic        unused_shamt;

    assign instr   = imem_q[core_q.pc[IA_W+1:2]];
    assign opcode  = instr[31:26];
    assign rs      = instr[25:21];
    assign rt      = instr[20:16];
    assign rd      = instr[15:11];
    assign funct   = instr[5:0];
    assign imm16   = instr[15:0];
    assign imm_ext = {{16{imm16[15]}}, imm16};
    assign unused_shamt = ^instr[10:6];

    sc_main_dec u_mdec (
        .opcode (opcode),
        .ctrl   (dec_ctrl)
    );

    sc_alu_dec u_adec (
        .cls   (dec_ctrl.cls),
        .funct (funct),
        .op    (alu_op),
        .xload (fn_xload),
        .known (fn_known)
    );

    sc_regfile #(.N_REGS(32), .DW(32)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (wr_idx),
        .wdata   (wr_val),
        .raddr_a (rs),
        .rdata_a (rs_val),
        .raddr_b (rt),
        .rdata_b (rt_val)
    );

    sc_alu #(.DW(32)) u_alu (
        .op   (alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Merge the function decoder's verdict into the opcode decoder's controls.
    always_comb begin
        ctrl = dec_ctrl;
        if (dec_ctrl.rtype) begin
            if (!fn_known) ctrl.reg_we = 1'b0;
            if (fn_xload)  ctrl.wb     = WB_MEM;
        end
    end

    assign alu_b     = ctrl.use_imm ? imm_ext : rt_val;
    assign dm_idx    = alu_y[DA_W+1:2];
    assign mem_rdata = dmem_q[dm_idx];

    always_comb begin
        pc_plus4 = core_q.pc + 32'd4;
        br_tgt   = pc_plus4 + (imm_ext << 2);
        jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};

        unique case (ctrl.dst)
            DST_RD:   wr_idx = rd;
            DST_LINK: wr_idx = LINK_REG;
            default:  wr_idx = rt;
        endcase

        unique case (ctrl.wb)
            WB_MEM:  wr_val = mem_rdata;
            WB_LINK: wr_val = pc_plus4;
            default: wr_val = alu_y;
        endcase

        rf_we = ctrl.reg_we && (wr_idx != 5'd0);

        core_d = core_q;
        unique case (ctrl.npc)
            NPC_JMP: core_d.pc = jmp_tgt;
            NPC_MEM: core_d.pc = mem_rdata;
            default: core_d.pc = (ctrl.branch && alu_zero) ? br_tgt : pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && ctrl.mem_we) begin
            dmem_q[dm_idx] <= rt_val;
        end
    end

    assign dbg_pc     = core_q.pc;
    assign dbg_wr_en  = rf_we;
    assign dbg_wr_idx = wr_idx;
    assign dbg_wr_val = wr_val;

endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] instr,
    input logic [31:0] pc,
    input logic        we,
    input logic [4:0]  widx,
    input logic [31:0] wval,
    input logic [31:0] rs_val
);

    logic [5:0]  op;
    logic [31:0] seq_pc;
    logic [31:0] jt;
    logic        known_op;

    assign op     = instr[31:26];
    assign seq_pc = pc + 32'd4;
    assign jt     = {seq_pc[31:28], instr[25:0], 2'b00};
    assign known_op = (op == OP_RTYPE) || (op == OP_JUMP) || (op == OP_CALL) ||
                      (op == OP_BEQ) || (op == OP_LOAD) || (op == OP_STORE) ||
                      (op == OP_MJUMP);

    a_r1_reset_pc: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc == 32'd0));

    a_r6_link_write: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CALL) |-> (we && (widx == 5'd31) && (wval == seq_pc)));

    a_r5_jump_target: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_JUMP) || (op == OP_CALL)) |=> (pc == $past(jt)));

    a_r8_mjump_no_write: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MJUMP) |-> !we);

    a_r3_store_no_write: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STORE) |-> !we);

    a_r4_branch_no_write: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BEQ) |-> !we);

    a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> !we);

    a_r10_unknown_step: assert property (@(posedge clk) disable iff (rst)
        !known_op |=> (pc == $past(seq_pc)));

    a_r9_zero_reads: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

    a_r9_no_zero_write: assert property (@(posedge clk) disable iff (rst)
        we |-> (widx != 5'd0));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .instr  (instr),
    .pc     (dbg_pc),
    .we     (dbg_wr_en),
    .widx   (dbg_wr_idx),
    .wval   (dbg_wr_val),
    .rs_val (rs_val)
);

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dbg_pc;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_idx;
    logic [31:0] dbg_wr_val;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sc_core u0 (
        .clk        (clk),
        .rst        (rst),
        .dbg_pc     (dbg_pc),
        .dbg_wr_en  (dbg_wr_en),
        .dbg_wr_idx (dbg_wr_idx),
        .dbg_wr_val (dbg_wr_val)
    );

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                          logic [4:0] rd, logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                          logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] tgt);
        return {op, tgt};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) u0.imem_q[i] = 32'd0;
    endtask

    task automatic put(input int w, input logic [31:0] v);
        u0.imem_q[w] = v;
    endtask

    task automatic restart();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Check the current cycle's PC and write, then advance one cycle.
    task automatic expect_cycle(input string req, input logic [31:0] pc_exp,
                                input logic we_exp, input logic [4:0] idx_exp,
                                input logic [31:0] val_exp);
        check(req, "pc", dbg_pc, pc_exp);
        check(req, "wr_en", {31'd0, dbg_wr_en}, {31'd0, we_exp});
        if (we_exp) begin
            check(req, "wr_idx", {27'd0, dbg_wr_idx}, {27'd0, idx_exp});
            check(req, "wr_val", dbg_wr_val, val_exp);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_alu();
        clear_prog();
        put(0,  enc_j(6'h03, 26'd1));
        put(1,  enc_r(5'd31, 5'd0, 5'd1, 6'h20));
        put(2,  enc_r(5'd1, 5'd1, 5'd2, 6'h20));
        put(3,  enc_r(5'd2, 5'd1, 5'd3, 6'h20));
        put(4,  enc_r(5'd0, 5'd1, 5'd4, 6'h22));
        put(5,  enc_r(5'd4, 5'd1, 5'd5, 6'h2A));
        put(6,  enc_r(5'd1, 5'd4, 5'd6, 6'h2A));
        put(7,  enc_r(5'd3, 5'd1, 5'd7, 6'h24));
        put(8,  enc_r(5'd2, 5'd1, 5'd8, 6'h25));
        put(9,  enc_r(5'd1, 5'd1, 5'd0, 6'h20));
        put(10, enc_r(5'd0, 5'd0, 5'd9, 6'h20));
        put(11, enc_r(5'd1, 5'd1, 5'd10, 6'h3F));
        put(12, enc_i(6'h3B, 5'd1, 5'd11, 16'h0004));
        restart();
        check("R1", "pc after reset", dbg_pc, 32'd0);
        expect_cycle("R6 R11", 32'd0,  1'b1, 5'd31, 32'd4);
        expect_cycle("R2 add", 32'd4,  1'b1, 5'd1,  32'd4);
        expect_cycle("R2 add", 32'd8,  1'b1, 5'd2,  32'd8);
        expect_cycle("R2 add", 32'd12, 1'b1, 5'd3,  32'd12);
        expect_cycle("R2 sub", 32'd16, 1'b1, 5'd4,  32'hFFFF_FFFC);
        expect_cycle("R2 slt", 32'd20, 1'b1, 5'd5,  32'd1);
        expect_cycle("R2 slt", 32'd24, 1'b1, 5'd6,  32'd0);
        expect_cycle("R2 and", 32'd28, 1'b1, 5'd7,  32'd4);
        expect_cycle("R2 or",  32'd32, 1'b1, 5'd8,  32'd12);
        expect_cycle("R9 write r0", 32'd36, 1'b0, 5'd0, 32'd0);
        expect_cycle("R9 read r0",  32'd40, 1'b1, 5'd9, 32'd0);
        expect_cycle("R10 funct",   32'd44, 1'b0, 5'd0, 32'd0);
        expect_cycle("R10 opcode",  32'd48, 1'b0, 5'd0, 32'd0);
        check("R10", "pc after unknown", dbg_pc, 32'd52);
    endtask

    task automatic t_memory();
        clear_prog();
        put(0,  enc_j(6'h03, 26'd1));
        put(1,  enc_r(5'd31, 5'd31, 5'd1, 6'h20));
        put(2,  enc_r(5'd1, 5'd1, 5'd2, 6'h20));
        put(3,  enc_i(6'h2B, 5'd1, 5'd2, 16'h0004));
        put(4,  enc_i(6'h23, 5'd1, 5'd3, 16'h0004));
        put(5,  enc_i(6'h23, 5'd2, 5'd4, 16'hFFFC));
        put(6,  enc_i(6'h2B, 5'd2, 5'd1, 16'h0000));
        put(7,  enc_r(5'd1, 5'd1, 5'd5, 6'h30));
        put(8,  enc_r(5'd2, 5'd2, 5'd6, 6'h20));
        put(9,  enc_r(5'd6, 5'd6, 5'd6, 6'h20));
        put(10, enc_i(6'h2B, 5'd6, 5'd6, 16'hFFFC));
        put(11, enc_i(6'h3E, 5'd6, 5'd0, 16'hFFFC));
        put(16, enc_r(5'd6, 5'd0, 5'd7, 6'h20));
        restart();
        expect_cycle("R6",       32'd0,  1'b1, 5'd31, 32'd4);
        expect_cycle("R2",       32'd4,  1'b1, 5'd1,  32'd8);
        expect_cycle("R2",       32'd8,  1'b1, 5'd2,  32'd16);
        expect_cycle("R3 store", 32'd12, 1'b0, 5'd0,  32'd0);
        expect_cycle("R3 load",  32'd16, 1'b1, 5'd3,  32'd16);
        expect_cycle("R3 neg offset", 32'd20, 1'b1, 5'd4, 32'd16);
        expect_cycle("R3 store", 32'd24, 1'b0, 5'd0,  32'd0);
        expect_cycle("R7 indexed load", 32'd28, 1'b1, 5'd5, 32'd8);
        expect_cycle("R2",       32'd32, 1'b1, 5'd6,  32'd32);
        expect_cycle("R2",       32'd36, 1'b1, 5'd6,  32'd64);
        expect_cycle("R3 store", 32'd40, 1'b0, 5'd0,  32'd0);
        expect_cycle("R8 no write", 32'd44, 1'b0, 5'd0, 32'd0);
        expect_cycle("R8 target", 32'd64, 1'b1, 5'd7, 32'd64);
    endtask

    task automatic t_control();
        clear_prog();
        put(0,  enc_i(6'h04, 5'd0, 5'd0, 16'h0002));
        put(3,  enc_j(6'h03, 26'd5));
        put(5,  enc_i(6'h04, 5'd31, 5'd0, 16'h0005));
        put(6,  enc_i(6'h04, 5'd0, 5'd0, 16'hFFFA));
        put(1,  enc_j(6'h02, 26'd10));
        restart();
        expect_cycle("R4 taken",     32'd0,  1'b0, 5'd0,  32'd0);
        expect_cycle("R6 call",      32'd12, 1'b1, 5'd31, 32'd16);
        expect_cycle("R4 not taken", 32'd20, 1'b0, 5'd0,  32'd0);
        expect_cycle("R4 backward",  32'd24, 1'b0, 5'd0,  32'd0);
        expect_cycle("R5 jump",      32'd4,  1'b0, 5'd0,  32'd0);
        expect_cycle("R5 landed",    32'd40, 1'b0, 5'd0,  32'd0);
        check("R10", "pc after empty word", dbg_pc, 32'd44);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        t_reset_alu();
        t_memory();
        t_control();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule